// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block tracks in-flight memory operations in program order and picks, each cycle, the oldest one that may issue under a relaxed ordering model. Dispatch presents one operation per cycle with an operation code and a sequence tag. Plain loads and stores are held against separate load and store capacity limits. Operations flagged with side effects act as ordering fences. A fence does not flush anything. It waits until every older operation has completed, and younger operations of the kind it fences wait until it has issued.

The execution side reports the slot of each issued operation back when the operation completes, and that frees its capacity. A mode input chooses whether loads may overtake older stores that have not issued yet. When either capacity is used up, a full flag tells dispatch to hold back.

Top module: `memord_q`

## Requirements
- R1: `alloc_op_i` is {side-effect, store, load} in bits 2..0. An operation with load set uses one load-queue entry, and one with store set uses one store-queue entry, so a full fence (3'b111) uses one of each. A depth parameter of 0 selects `DEF_DEPTH` entries for that queue.
- R2: `ld_full_o` (`st_full_o`) is high while the load (store) queue holds its capacity or the shared ring is full. An allocation that needs a full queue is dropped and never issues.
- R3: A store (3'b010) issues only once every older load, store and fence that loads or stores has issued.
- R4: A load (3'b001) may overtake an older store that has not issued only while `noalias_i` is 1. With `noalias_i` at 0 it waits for all older stores.
- R5: A load fence (3'b101) issues only when no older operation remains uncompleted. Younger loads and stores wait until it has issued.
- R6: A store fence (3'b110) issues only when no older operation remains uncompleted. Younger stores wait until it has issued, while younger loads may pass it when `noalias_i` is 1.
- R7: A full fence (3'b111) issues only when it is the oldest remaining entry, and blocks both younger loads and younger stores until it has issued.
- R8: At most one operation issues per cycle, and it is the oldest eligible one. An operation accepted at a clock edge can issue, with `issue_tag_o` equal to its tag, in the cycle that follows that edge.
- R9: `complete_valid_i` with `complete_slot_i` frees that entry at the clock edge. A full flag held only by the count of entries drops right after that edge, and the freed capacity can be allocated again.
- R10: After reset no entry is held, `issue_valid_o` is 0 and both full flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noalias_i | input | 1 | 1: loads may pass older unissued stores |
| alloc_valid_i | input | 1 | Allocation request from dispatch |
| alloc_op_i | input | 3 | {side-effect, store, load} |
| alloc_tag_i | input | TAG_W | Sequence tag of the operation |
| issue_valid_o | output | 1 | An operation issues this cycle |
| issue_slot_o | output | SW | Slot of the issuing operation |
| issue_tag_o | output | TAG_W | Tag of the issuing operation |
| complete_valid_i | input | 1 | An issued operation has completed |
| complete_slot_i | input | SW | Slot of the completed operation |
| ld_full_o | output | 1 | Load capacity exhausted, hold loads |
| st_full_o | output | 1 | Store capacity exhausted, hold stores |

## Verification
An operation accepted at one edge can appear on the issue port in the next cycle. A completion presented at an edge changes the count-based full flags right after that same edge, and it releases a fence waiting behind the freed entry for the following cycle. The bench drives its inputs on falling edges and samples two nanoseconds after each rising edge, so each issue cycle is seen exactly once. A scoreboard holds the expected tag order for each scenario. Any issue it does not expect counts as a failure, which also shows that blocked or dropped operations stay silent while they are held. Flag checks are placed in the cycle right after the edge that should change them.

// File: rtl/memord_q.sv
module memord_q #(
  parameter int LQ_DEPTH  = 8,
  parameter int SQ_DEPTH  = 8,
  parameter int DEF_DEPTH = 16,
  parameter int TAG_W     = 8,
  localparam int LQE  = (LQ_DEPTH == 0) ? DEF_DEPTH : LQ_DEPTH,
  localparam int SQE  = (SQ_DEPTH == 0) ? DEF_DEPTH : SQ_DEPTH,
  localparam int RING = LQE + SQE,
  localparam int SW   = (RING > 1) ? $clog2(RING) : 1,
  localparam int CW   = $clog2(RING + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             noalias_i,
  input  logic             alloc_valid_i,
  input  logic [2:0]       alloc_op_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  output logic             issue_valid_o,
  output logic [SW-1:0]    issue_slot_o,
  output logic [TAG_W-1:0] issue_tag_o,
  input  logic             complete_valid_i,
  input  logic [SW-1:0]    complete_slot_i,
  output logic             ld_full_o,
  output logic             st_full_o
);

  logic [RING-1:0]  vld_q, iss_q;
  logic [2:0]       op_q  [RING];
  logic [TAG_W-1:0] tag_q [RING];
  logic [SW-1:0]    head_q, tail_q;
  logic [CW-1:0]    used_q, lq_cnt_q, sq_cnt_q;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (int'(p) == RING - 1) ? '0 : p + 1'b1;
  endfunction

  logic          pick;
  logic [SW-1:0] pick_slot;
  logic          any_old, p_ld, p_st, b_ld, b_st, ok;
  logic          e_ld, e_st, e_se;
  int            s;

  always_comb begin
    pick = 1'b0; pick_slot = '0;
    any_old = 1'b0; p_ld = 1'b0; p_st = 1'b0; b_ld = 1'b0; b_st = 1'b0;
    ok = 1'b0; e_ld = 1'b0; e_st = 1'b0; e_se = 1'b0; s = 0;
    for (int k = 0; k < RING; k++) begin
      s = int'(head_q) + k;
      if (s >= RING) s = s - RING;
      if (k < int'(used_q) && vld_q[s]) begin
        e_ld = op_q[s][0];
        e_st = op_q[s][1];
        e_se = op_q[s][2];
        if (!iss_q[s]) begin
          if (e_se)              ok = !any_old;
          else if (e_ld && e_st) ok = !p_ld && !p_st && !b_ld && !b_st;
          else if (e_st)         ok = !p_ld && !p_st && !b_st;
          else                   ok = !b_ld && !(p_st && !noalias_i);
          if (ok && !pick) begin
            pick      = 1'b1;
            pick_slot = SW'(s);
          end
          p_ld = p_ld | e_ld;
          p_st = p_st | e_st;
          b_ld = b_ld | (e_se & e_ld);
          b_st = b_st | (e_se & e_st);
        end
        any_old = 1'b1;
      end
    end
  end

  wire need_l = alloc_op_i[0];
  wire need_s = alloc_op_i[1];
  wire acc    = alloc_valid_i && (need_l || need_s)
             && (!need_l || lq_cnt_q < CW'(LQE))
             && (!need_s || sq_cnt_q < CW'(SQE))
             && (used_q < CW'(RING));
  wire adv    = (used_q != '0) && !vld_q[head_q];
  wire done   = complete_valid_i && (int'(complete_slot_i) < RING) && vld_q[complete_slot_i];
  wire done_l = done && op_q[complete_slot_i][0];
  wire done_s = done && op_q[complete_slot_i][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      iss_q    <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      used_q   <= '0;
      lq_cnt_q <= '0;
      sq_cnt_q <= '0;
    end else begin
      if (pick) iss_q[pick_slot] <= 1'b1;
      if (done) vld_q[complete_slot_i] <= 1'b0;
      if (acc) begin
        vld_q[tail_q] <= 1'b1;
        iss_q[tail_q] <= 1'b0;
        tail_q        <= nxt(tail_q);
      end
      if (adv) head_q <= nxt(head_q);
      used_q   <= used_q + CW'(acc) - CW'(adv);
      lq_cnt_q <= lq_cnt_q + CW'(acc && need_l) - CW'(done_l);
      sq_cnt_q <= sq_cnt_q + CW'(acc && need_s) - CW'(done_s);
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      op_q[tail_q]  <= alloc_op_i;
      tag_q[tail_q] <= alloc_tag_i;
    end
  end

  assign issue_valid_o = pick;
  assign issue_slot_o  = pick_slot;
  assign issue_tag_o   = tag_q[pick_slot];
  assign ld_full_o     = (lq_cnt_q == CW'(LQE)) || (used_q == CW'(RING));
  assign st_full_o     = (sq_cnt_q == CW'(SQE)) || (used_q == CW'(RING));

endmodule

// File: rtl/memord_q_chk.sv
module memord_q_chk #(
  parameter int LQ_DEPTH  = 8,
  parameter int SQ_DEPTH  = 8,
  parameter int DEF_DEPTH = 16,
  localparam int LQE  = (LQ_DEPTH == 0) ? DEF_DEPTH : LQ_DEPTH,
  localparam int SQE  = (SQ_DEPTH == 0) ? DEF_DEPTH : SQ_DEPTH,
  localparam int RING = LQE + SQE,
  localparam int SW   = (RING > 1) ? $clog2(RING) : 1,
  localparam int CW   = $clog2(RING + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid_i,
  input logic [2:0]      alloc_op_i,
  input logic            issue_valid_o,
  input logic [SW-1:0]   issue_slot_o,
  input logic            ld_full_o,
  input logic            st_full_o,
  input logic [RING-1:0] vld_q,
  input logic [RING-1:0] iss_q,
  input logic [CW-1:0]   lq_cnt_q,
  input logic [CW-1:0]   sq_cnt_q
);

  assert_issue_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (vld_q[issue_slot_o] && !iss_q[issue_slot_o]));

  assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |=> !(issue_valid_o && issue_slot_o == $past(issue_slot_o)));

  assert_cap_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_cnt_q <= CW'(LQE)) && (sq_cnt_q <= CW'(SQE)));

  assert_ld_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid_i && alloc_op_i[0] && ld_full_o) |=> lq_cnt_q <= $past(lq_cnt_q));

  assert_st_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid_i && alloc_op_i[1] && st_full_o) |=> sq_cnt_q <= $past(sq_cnt_q));

endmodule

bind memord_q memord_q_chk #(
  .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .DEF_DEPTH(DEF_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid_i(alloc_valid_i), .alloc_op_i(alloc_op_i),
  .issue_valid_o(issue_valid_o), .issue_slot_o(issue_slot_o),
  .ld_full_o(ld_full_o), .st_full_o(st_full_o),
  .vld_q(vld_q), .iss_q(iss_q), .lq_cnt_q(lq_cnt_q), .sq_cnt_q(sq_cnt_q)
);

// File: tb/tb_memord_q.sv
module tb_memord_q;
  localparam int SW = 4;
  localparam logic [2:0] OP_L = 3'b001, OP_S = 3'b010, OP_LB = 3'b101,
                         OP_SB = 3'b110, OP_FB = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, noalias = 1'b1;
  logic alloc_valid = 1'b0, complete_valid = 1'b0;
  logic [2:0] alloc_op = '0;
  logic [7:0] alloc_tag = '0;
  logic [SW-1:0] complete_slot = '0;
  logic issue_valid, ld_full, st_full;
  logic [SW-1:0] issue_slot;
  logic [7:0] issue_tag;

  always #5 clk = ~clk;

  memord_q #(.LQ_DEPTH(4), .SQ_DEPTH(0), .DEF_DEPTH(8), .TAG_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .noalias_i(noalias),
    .alloc_valid_i(alloc_valid), .alloc_op_i(alloc_op), .alloc_tag_i(alloc_tag),
    .issue_valid_o(issue_valid), .issue_slot_o(issue_slot), .issue_tag_o(issue_tag),
    .complete_valid_i(complete_valid), .complete_slot_i(complete_slot),
    .ld_full_o(ld_full), .st_full_o(st_full));

  int checks = 0, fails = 0;
  int exp_tag[$];
  string exp_req[$];
  string cur_req = "R10";
  logic [SW-1:0] slot_of [256];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && issue_valid) begin
      slot_of[issue_tag] = issue_slot;
      if (exp_tag.size() == 0) check(1'b0, cur_req, "unexpected issue tag", int'(issue_tag), -1);
      else begin
        check(int'(issue_tag) == exp_tag[0], exp_req[0], "issue order tag", int'(issue_tag), exp_tag[0]);
        void'(exp_tag.pop_front());
        void'(exp_req.pop_front());
      end
    end
  end

  task automatic expect_tag(input int t, input string req);
    exp_tag.push_back(t);
    exp_req.push_back(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; alloc_valid = 1'b0; complete_valid = 1'b0;
    repeat (2) @(negedge clk);
    exp_tag.delete(); exp_req.delete();
    rst_n = 1'b1;
  endtask

  task automatic alloc(input logic [2:0] op, input int t);
    @(negedge clk);
    complete_valid = 1'b0;
    alloc_valid = 1'b1; alloc_op = op; alloc_tag = 8'(t);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    alloc_valid = 1'b0; complete_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic complete(input int t);
    @(negedge clk);
    alloc_valid = 1'b0;
    complete_valid = 1'b1; complete_slot = slot_of[t];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, cur_req, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(posedge clk); #2;
    check(!issue_valid, "R10", "issue_valid after reset", int'(issue_valid), 0);
    check(!ld_full, "R10", "ld_full after reset", int'(ld_full), 0);
    check(!st_full, "R10", "st_full after reset", int'(st_full), 0);

    cur_req = "R5"; noalias = 1'b1;
    expect_tag(1, "R8"); expect_tag(2, "R5"); expect_tag(3, "R5"); expect_tag(4, "R3");
    alloc(OP_L, 1); alloc(OP_LB, 2); alloc(OP_L, 3); alloc(OP_S, 4); idle(6);
    check(exp_tag.size() == 3, "R5", "ops held behind load fence", exp_tag.size(), 3);
    complete(1); idle(6);
    check(exp_tag.size() == 0, "R5", "ops left after fence release", exp_tag.size(), 0);

    do_reset(); cur_req = "R6"; noalias = 1'b1;
    expect_tag(20, "R8"); expect_tag(23, "R4"); expect_tag(21, "R6"); expect_tag(22, "R6");
    alloc(OP_L, 20); alloc(OP_SB, 21); alloc(OP_S, 22); alloc(OP_L, 23); idle(6);
    check(exp_tag.size() == 2, "R6", "store held behind store fence", exp_tag.size(), 2);
    complete(20); idle(6);
    check(exp_tag.size() == 0, "R6", "ops left after fence release", exp_tag.size(), 0);

    do_reset(); cur_req = "R4"; noalias = 1'b0;
    expect_tag(30, "R8"); expect_tag(31, "R6"); expect_tag(32, "R3"); expect_tag(33, "R4");
    alloc(OP_L, 30); alloc(OP_SB, 31); alloc(OP_S, 32); alloc(OP_L, 33); idle(6);
    check(exp_tag.size() == 3, "R4", "load held behind store without noalias", exp_tag.size(), 3);
    complete(30); idle(6);
    check(exp_tag.size() == 0, "R4", "ops left after release", exp_tag.size(), 0);

    do_reset(); cur_req = "R7"; noalias = 1'b1;
    expect_tag(40, "R8"); expect_tag(41, "R7"); expect_tag(42, "R7"); expect_tag(43, "R7");
    alloc(OP_L, 40); alloc(OP_FB, 41); alloc(OP_L, 42); alloc(OP_S, 43); idle(6);
    check(exp_tag.size() == 3, "R7", "ops held behind full fence", exp_tag.size(), 3);
    complete(40); idle(6);
    check(exp_tag.size() == 0, "R7", "ops left after full fence", exp_tag.size(), 0);

    do_reset(); cur_req = "R8";
    expect_tag(60, "R8");
    alloc(OP_L, 60);
    @(posedge clk); #3;
    check(issue_valid && issue_tag == 8'd60, "R8", "issue in cycle after accept", int'(issue_tag), 60);
    expect_tag(61, "R8"); expect_tag(62, "R3");
    alloc(OP_L, 61); alloc(OP_S, 62); idle(4);
    check(exp_tag.size() == 0, "R8", "back-to-back issue", exp_tag.size(), 0);

    do_reset(); cur_req = "R2";
    for (int i = 80; i < 84; i++) expect_tag(i, "R1");
    for (int i = 80; i < 84; i++) alloc(OP_L, i);
    idle(3);
    check(ld_full, "R2", "ld_full at load capacity", int'(ld_full), 1);
    check(!st_full, "R2", "st_full with loads only", int'(st_full), 0);
    alloc(OP_L, 84); idle(4);
    check(ld_full, "R2", "ld_full after dropped load", int'(ld_full), 1);
    complete(82);
    @(posedge clk); #3;
    check(!ld_full, "R9", "ld_full after completion", int'(ld_full), 0);
    expect_tag(85, "R9");
    alloc(OP_L, 85); idle(4);
    check(exp_tag.size() == 0, "R9", "reused load capacity", exp_tag.size(), 0);

    do_reset(); cur_req = "R2";
    for (int i = 90; i < 98; i++) expect_tag(i, "R1");
    for (int i = 90; i < 98; i++) alloc(OP_S, i);
    idle(3);
    check(st_full, "R1", "st_full at default store depth", int'(st_full), 1);
    check(!ld_full, "R1", "ld_full with stores only", int'(ld_full), 0);
    alloc(OP_S, 98); idle(4);
    complete(93);
    @(posedge clk); #3;
    check(!st_full, "R9", "st_full after completion", int'(st_full), 0);
    expect_tag(99, "R9");
    alloc(OP_S, 99); idle(4);
    check(exp_tag.size() == 0, "R9", "reused store capacity", exp_tag.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule